// File: doc/BRIEF.md
# Striped Burst Request Splitter

This block takes one write request, given as a start address and a length in memory words. It cuts the request into fixed-size bursts and hands each burst to one of several memory regions. The regions are used in strict rotation, so the traffic of a long transfer is spread evenly across them. Each region has its own burst command channel with valid/ready flow control. A region that holds off its ready line stalls the whole sequence. No burst is dropped or reordered.

Upstream, a valid/ready request channel carries the address and the length. The block accepts one request at a time. It takes no new request until the last burst of the current one has been handed off. A one-cycle completion pulse then marks the end of the request. The block produces only burst commands. It carries no data beats.

Top module: `stripe_splitter`

## Requirements
- R1: After reset `req_ready` is 1, every bit of `bst_valid` is 0 and `done` is 0.
- R2: A request of L words (L > 0) produces ceil(L/64) bursts. Every burst carries a length of 64 on `bst_len`, except the final one, which carries L minus 64 times the number of earlier bursts (a value from 1 to 64).
- R3: Burst number k (counting from 0 in each request) is presented on region channel k mod 4. So bursts 0, 1, 2 and 3 go to regions 0, 1, 2 and 3, in that order.
- R4: The address of burst k equals the request start address plus 64·k, modulo 2^ADDR_W.
- R5: A request longer than 256 words continues the rotation: after region 3 the next burst goes to region 0 again.
- R6: From the accepting edge until the final burst handshake, `req_ready` is 0 and no further request is taken.
- R7: While the selected region holds its ready line at 0, the same region keeps its valid at 1, with the address and length unchanged.
- R8: A request with length 0 is accepted, raises `done` for the single following cycle and raises no `bst_valid` bit.
- R9: `done` is 1 for exactly one cycle, the one that follows the handshake of the final burst. In that cycle `req_ready` is 1 again.
- R10: At most one bit of `bst_valid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Length in words |
| bst_valid | output | REGIONS | Per-region burst valid |
| bst_ready | input | REGIONS | Per-region burst ready |
| bst_addr | output | REGIONS*ADDR_W | Per-region burst address, region r at bits r*ADDR_W upward |
| bst_len | output | REGIONS*BLEN_W | Per-region burst length, region r at bits r*BLEN_W upward (BLEN_W = clog2(BURST_WORDS)+1) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 64-word bursts, four regions, 32-bit addresses and 16-bit lengths. With these values, a 600-word request covers more than two full rotations and ends in a 24-word remainder. Requests of exactly 64 and 256 words reach the cases where the final burst is full. A 1-word request hits the smallest remainder. A request with alternating ready stalls shows that bursts hold still and keep their order under backpressure.

// File: rtl/stripe_splitter.sv
module stripe_splitter #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_WORDS = 64,
  parameter int REGIONS     = 4,
  localparam int BLEN_W     = $clog2(BURST_WORDS) + 1,
  localparam int RIDX_W     = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [LEN_W-1:0]            req_len,
  output logic [REGIONS-1:0]          bst_valid,
  input  logic [REGIONS-1:0]          bst_ready,
  output logic [REGIONS*ADDR_W-1:0]   bst_addr,
  output logic [REGIONS*BLEN_W-1:0]   bst_len,
  output logic                        done
);

  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [RIDX_W-1:0] region;
  logic              done_q;

  wire              last  = remain <= LEN_W'(BURST_WORDS);
  wire [BLEN_W-1:0] blen  = last ? remain[BLEN_W-1:0] : BLEN_W'(BURST_WORDS);
  wire              fire  = busy && bst_ready[region];
  wire              take  = req_valid && req_ready;
  wire [RIDX_W-1:0] r_nxt = (region == RIDX_W'(REGIONS - 1)) ? '0 : region + 1'b1;

  assign req_ready = !busy;
  assign done      = done_q;

  for (genvar g = 0; g < REGIONS; g++) begin : g_chan
    assign bst_valid[g]                  = busy && (region == RIDX_W'(g));
    assign bst_addr[g*ADDR_W +: ADDR_W]  = cur_addr;
    assign bst_len[g*BLEN_W +: BLEN_W]   = blen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      region   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        cur_addr <= req_addr;
        remain   <= req_len;
        region   <= '0;
        busy     <= req_len != '0;
        done_q   <= req_len == '0;
      end else if (fire) begin
        cur_addr <= cur_addr + ADDR_W'(BURST_WORDS);
        region   <= r_nxt;
        if (last) begin
          busy   <= 1'b0;
          remain <= '0;
          done_q <= 1'b1;
        end else begin
          remain <= remain - LEN_W'(BURST_WORDS);
        end
      end
    end
  end

  p_one_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bst_valid));

  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (blen != '0 && blen <= BLEN_W'(BURST_WORDS)));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bst_ready[region]) |=> (busy && $stable(region) && $stable(cur_addr) && $stable(remain)));

  p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (busy && region != $past(region)));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (done && req_ready && bst_valid == '0));

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_len == '0) |=> (done && bst_valid == '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(req_valid));

  p_first_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_len != '0) |=> bst_valid[0]);

endmodule

// File: tb/stripe_splitter_bench.sv
module stripe_splitter_bench;
  localparam int ADDR_W = 32, LEN_W = 16, BW = 64, NR = 4;
  localparam int BLEN_W = $clog2(BW) + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, done;
  logic [NR-1:0] bst_valid, bst_ready = '1;
  logic [NR*ADDR_W-1:0] bst_addr;
  logic [NR*BLEN_W-1:0] bst_len;

  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  stripe_splitter u_stripe_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .bst_valid(bst_valid),
    .bst_ready(bst_ready), .bst_addr(bst_addr), .bst_len(bst_len), .done(done));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [ADDR_W-1:0] a, input int len, input bit stall);
    int nb, k, r;
    bit tog;
    logic [ADDR_W-1:0] ea;
    nb = (len + BW - 1) / BW;
    k = 0; tog = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_len = LEN_W'(len); bst_ready = '1;
    @(negedge clk);
    if (len == 0) begin
      req_valid = 0;
      chk(done == 1'b1, "R8 done after zero-length", done, 1);
      chk(bst_valid == '0, "R8 no burst for zero-length", bst_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", done, 0);
      chk(bst_valid == '0, "R8 still no burst", bst_valid, 0);
      return;
    end
    while (k < nb) begin
      r = k % NR;
      ea = a + ADDR_W'(BW * k);
      chk(req_ready == 1'b0, "R6 not ready while busy", req_ready, 0);
      chk($countones(bst_valid) <= 1, "R10 one region valid", $countones(bst_valid), 1);
      chk(bst_valid == NR'(1 << r), "R3/R5 region of burst", bst_valid, 1 << r);
      chk(bst_addr[r*ADDR_W +: ADDR_W] == ea, "R4 burst address", bst_addr[r*ADDR_W +: ADDR_W], ea);
      chk(int'(bst_len[r*BLEN_W +: BLEN_W]) == ((k < nb - 1) ? BW : len - BW * (nb - 1)),
          "R2 burst length", bst_len[r*BLEN_W +: BLEN_W], (k < nb - 1) ? BW : len - BW * (nb - 1));
      if (stall) begin tog = !tog; bst_ready = tog ? '0 : '1; end
      else bst_ready = '1;
      if (!stall) chk(done == 1'b0, "R9 no early done", done, 0);
      if (bst_ready[r]) begin
        k++;
        if (k == nb) req_valid = 0;
      end else begin
        @(negedge clk);
        chk(bst_valid == NR'(1 << r), "R7 stalled region holds", bst_valid, 1 << r);
        chk(bst_addr[r*ADDR_W +: ADDR_W] == ea, "R7 stalled address stable", bst_addr[r*ADDR_W +: ADDR_W], ea);
        bst_ready = '1;
        k++;
        if (k == nb) req_valid = 0;
      end
      @(negedge clk);
    end
    chk(done == 1'b1, "R9 done after last burst", done, 1);
    chk(req_ready == 1'b1, "R9 ready with done", req_ready, 1);
    chk(bst_valid == '0, "R9 no burst after end", bst_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(bst_valid == '0, "R1 no valid after reset", bst_valid, 0);
    chk(done == 1'b0, "R1 done low after reset", done, 0);
  endtask

  task automatic t_four_bursts;   run_req(32'h0000_1000, 256, 0); endtask
  task automatic t_wrap;          run_req(32'hFFFF_FF80, 600, 0); endtask
  task automatic t_exact_one;     run_req(32'h0000_0040, 64, 0); endtask
  task automatic t_single_word;   run_req(32'h0000_0007, 1, 0); endtask
  task automatic t_stall;         run_req(32'h0002_0000, 300, 1); endtask
  task automatic t_zero;          run_req(32'h0000_0123, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_four_bursts();
    t_wrap();
    t_exact_one();
    t_single_word();
    t_stall();
    t_zero();
    t_four_bursts();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule